// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog that counts on its own slow clock, separate from the bus clock that software uses to program it. A 12-bit down counter decrements once per prescaler period. When a prescaler period ends with the counter already at zero, the block raises a one-cycle reset request and restarts the countdown. Software never writes the counter directly. Instead it writes 16-bit key words to a control address: one key arms the watchdog, one refreshes the counter, and one opens the divider and reload registers for a single burst of writes.

The divider and reload values are held in the bus domain and carried into the watchdog domain by toggle handshakes. While a handshake is in flight, a busy flag stays up, so software can tell when the new value is live. A strap input can start the watchdog straight out of reset without any key. A debug pair, halt together with hold, freezes the countdown while the core is stopped.

Top module: `keyed_watchdog`

## Requirements
- R1: Before it is armed, the block never asserts `wdg_rst_o`. The watchdog is armed by writing 0xCCCC to address 0, or by `hw_start`.
- R2: Once armed, the counter decrements once per prescaler period. A period that ends with the counter at 0 drives `wdg_rst_o` high for exactly one `wdg_clk` cycle and reloads the counter from the reload register. With reload value N and divide D, consecutive pulses are therefore (N+1)*D `wdg_clk` cycles apart.
- R3: Writing 0xAAAA to address 0 loads the counter from the reload register, whether or not the watchdog is armed.
- R4: Writes to address 1 (divider, bits 2:0) and address 2 (reload, bits 11:0) are ignored unless the most recent write to address 0 was 0x5555. Any other value written to address 0 locks them again.
- R5: A divider code c gives a period of 4<<c `wdg_clk` cycles for c from 0 to 6. Code 7 behaves like code 6 (divide by 256).
- R6: Address 3 reads divider-busy in bit 0 and reload-busy in bit 1. A busy bit rises on the bus edge that accepts the write. It falls on the second bus edge after the watchdog domain has taken the new value.
- R7: When `hw_start` is high out of reset, the watchdog counts with no arming key.
- R8: While `dbg_hold` and `dbg_halt` are both high, neither the counter nor the prescaler moves. With `dbg_hold` low, a halt has no effect.
- R9: Once armed, no control-register write disarms the watchdog. Only `rst_n` does.
- R10: After reset, address 1 reads 0, address 2 reads 0xFFF, address 3 reads 0, address 0 reads 0, `wdg_rst_o` is low, and the counter holds 0xFFF.
- R11: If a key or register write is accepted on a bus edge falling between `wdg_clk` edges k and k+1, the refresh, divider or reload value takes effect at `wdg_clk` edge k+3. An arming key makes the first count happen at edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control keys, 1 divider, 2 reload |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Combinational read data |
| wdg_clk | input | 1 | Independent watchdog clock |
| hw_start | input | 1 | Strap that arms the watchdog from reset |
| dbg_halt | input | 1 | Core halted in debug, synchronous to `wdg_clk` |
| dbg_hold | input | 1 | Enables freezing during debug halt |
| wdg_rst_o | output | 1 | One-cycle reset request in the `wdg_clk` domain |

## Verification
The assertions rely on four things about the environment. Software does not write the divider or reload register while that register's busy bit is up. It spaces refresh keys so that no two are in flight at once. `hw_start` does not change while out of reset, and the debug inputs are synchronous to `wdg_clk`. The stimulus keeps to these rules: it polls the bench model's busy state before every protected write, it waits dozens of watchdog cycles between refresh keys, it changes `hw_start` only while reset is held, and it drives the debug inputs on the falling edge of `wdg_clk`. The two clocks have a fixed ratio, and their edges never coincide, so every crossing has a known latency.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int          CW       = 12,
  parameter logic [15:0] KEY_RUN  = 16'hCCCC,
  parameter logic [15:0] KEY_KICK = 16'hAAAA,
  parameter logic [15:0] KEY_OPEN = 16'h5555
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [15:0] rd_data,
  input  logic        wdg_clk,
  input  logic        hw_start,
  input  logic        dbg_halt,
  input  logic        dbg_hold,
  output logic        wdg_rst_o
);
  localparam int PRE_W   = 8;
  localparam int DIV_TOP = 6;

  logic          unlocked, run_req, kick_req, psc_req, rld_req;
  logic [2:0]    psc_sh;
  logic [CW-1:0] rld_sh;
  logic [1:0]    psc_ack_s, rld_ack_s;

  logic [1:0]    run_s;
  logic [2:0]    kick_s, psc_s, rld_s;
  logic [2:0]    psc_w;
  logic [CW-1:0] rld_w, cnt;
  logic [PRE_W-1:0] pre;

  wire ctl_wr = wr_en && wr_addr == 2'd0;
  wire psc_wr = wr_en && wr_addr == 2'd1 && unlocked;
  wire rld_wr = wr_en && wr_addr == 2'd2 && unlocked;

  wire psc_busy = psc_req ^ psc_ack_s[1];
  wire rld_busy = rld_req ^ rld_ack_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked  <= 1'b0;
      run_req   <= 1'b0;
      kick_req  <= 1'b0;
      psc_req   <= 1'b0;
      rld_req   <= 1'b0;
      psc_sh    <= '0;
      rld_sh    <= '1;
      psc_ack_s <= '0;
      rld_ack_s <= '0;
    end else begin
      psc_ack_s <= {psc_ack_s[0], psc_s[2]};
      rld_ack_s <= {rld_ack_s[0], rld_s[2]};
      if (ctl_wr) begin
        unlocked <= wr_data == KEY_OPEN;
        if (wr_data == KEY_RUN)  run_req  <= 1'b1;
        if (wr_data == KEY_KICK) kick_req <= ~kick_req;
      end
      if (psc_wr) begin
        psc_sh  <= wr_data[2:0];
        psc_req <= ~psc_req;
      end
      if (rld_wr) begin
        rld_sh  <= wr_data[CW-1:0];
        rld_req <= ~rld_req;
      end
    end
  end

  always_comb begin
    case (rd_addr)
      2'd1:    rd_data = {13'd0, psc_sh};
      2'd2:    rd_data = {{(16-CW){1'b0}}, rld_sh};
      2'd3:    rd_data = {14'd0, rld_busy, psc_busy};
      default: rd_data = '0;
    endcase
  end

  wire kick_p = kick_s[1] ^ kick_s[2];
  wire psc_p  = psc_s[1] ^ psc_s[2];
  wire rld_p  = rld_s[1] ^ rld_s[2];

  wire        en_run  = hw_start | run_s[1];
  wire        frz     = dbg_hold & dbg_halt;
  wire        step    = en_run & ~frz;
  wire [2:0]  psc_eff = (psc_w > 3'(DIV_TOP)) ? 3'(DIV_TOP) : psc_w;
  wire [PRE_W:0]   div_len = (PRE_W+1)'(4) << psc_eff;
  wire [PRE_W-1:0] pre_top = PRE_W'(div_len - 1'b1);
  wire        tick    = step && pre >= pre_top;
  wire        expire  = tick && cnt == '0;

  always_ff @(posedge wdg_clk or negedge rst_n) begin
    if (!rst_n) begin
      run_s     <= '0;
      kick_s    <= '0;
      psc_s     <= '0;
      rld_s     <= '0;
      psc_w     <= '0;
      rld_w     <= '1;
      cnt       <= '1;
      pre       <= '0;
      wdg_rst_o <= 1'b0;
    end else begin
      run_s  <= {run_s[0], run_req};
      kick_s <= {kick_s[1:0], kick_req};
      psc_s  <= {psc_s[1:0], psc_req};
      rld_s  <= {rld_s[1:0], rld_req};
      if (psc_p) psc_w <= psc_sh;
      if (rld_p) rld_w <= rld_sh;
      if (!en_run)   pre <= '0;
      else if (step) pre <= tick ? '0 : pre + 1'b1;
      if (kick_p || expire) cnt <= rld_w;
      else if (tick)        cnt <= cnt - 1'b1;
      wdg_rst_o <= expire;
    end
  end
endmodule

// File: rtl/keyed_watchdog_checks.sv
module keyed_watchdog_checks #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          wdg_clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [1:0]    wr_addr,
  input logic          unlocked,
  input logic [2:0]    psc_sh,
  input logic [CW-1:0] rld_sh,
  input logic          psc_busy,
  input logic          rld_busy,
  input logic          en_run,
  input logic          frz,
  input logic          kick_p,
  input logic [CW-1:0] cnt,
  input logic          hw_start,
  input logic          wdg_rst_o
);
  // R1
  idle_quiet_chk: assert property (@(posedge wdg_clk) disable iff (!rst_n)
    !en_run |=> !wdg_rst_o);

  // R2
  pulse_width_chk: assert property (@(posedge wdg_clk) disable iff (!rst_n)
    wdg_rst_o |=> !wdg_rst_o);

  // R4
  psc_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1 && !unlocked) |=> $stable(psc_sh));

  // R4
  rld_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2 && !unlocked) |=> $stable(rld_sh));

  // R6
  psc_busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(psc_busy) |-> $past(wr_en && wr_addr == 2'd1));

  // R6
  rld_busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rld_busy) |-> $past(wr_en && wr_addr == 2'd2));

  // R6
  psc_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 2'd1 && unlocked && psc_busy));

  // R6
  rld_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 2'd2 && unlocked && rld_busy));

  // R7
  strap_steady_chk: assert property (@(posedge wdg_clk) disable iff (!rst_n)
    $stable(hw_start));

  // R8
  freeze_chk: assert property (@(posedge wdg_clk) disable iff (!rst_n)
    (frz && !kick_p) |=> $stable(cnt));

  // R9
  armed_sticky_chk: assert property (@(posedge wdg_clk) disable iff (!rst_n)
    en_run |=> en_run);
endmodule

bind keyed_watchdog keyed_watchdog_checks #(.CW(CW)) u_checks (
  .clk      (clk),
  .wdg_clk  (wdg_clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .unlocked (unlocked),
  .psc_sh   (psc_sh),
  .rld_sh   (rld_sh),
  .psc_busy (psc_busy),
  .rld_busy (rld_busy),
  .en_run   (en_run),
  .frz      (frz),
  .kick_p   (kick_p),
  .cnt      (cnt),
  .hw_start (hw_start),
  .wdg_rst_o(wdg_rst_o)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
  logic        clk = 1'b0, wdg_clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        hw_start = 1'b0, dbg_halt = 1'b0, dbg_hold = 1'b0;
  logic        wdg_rst_o;

  always #2.5 clk = ~clk;
  always #20  wdg_clk = ~wdg_clk;

  keyed_watchdog u_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wdg_clk(wdg_clk), .hw_start(hw_start),
    .dbg_halt(dbg_halt), .dbg_hold(dbg_hold), .wdg_rst_o(wdg_rst_o));

  int vectors = 0, miscompares = 0;
  string cur_req = "R10";

  int bcnt = 0, wcnt = 0;
  int run_t = -1, kick_t = -1, psc_t = -1, rld_t = -1, pb_t = -1, rb_t = -1;
  bit m_unl = 0, m_run_req = 0, m_pb = 0, m_rb = 0;
  int m_psc_sh = 0, m_rld_sh = 'hFFF;
  bit m_en = 0, m_bark = 0;
  int m_psc = 0, m_rld = 'hFFF, m_cnt = 'hFFF, m_pre = 0;

  // bus-side model
  always @(posedge clk) begin
    bcnt++;
    if (!rst_n) begin
      m_unl = 0; m_run_req = 0; m_pb = 0; m_rb = 0;
      m_psc_sh = 0; m_rld_sh = 'hFFF;
      run_t = -1; kick_t = -1; psc_t = -1; rld_t = -1; pb_t = -1; rb_t = -1;
    end else begin
      if (bcnt == pb_t) m_pb = 0;
      if (bcnt == rb_t) m_rb = 0;
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin
            if (wr_data == 16'hCCCC && !m_run_req) begin m_run_req = 1; run_t = wcnt + 2; end
            if (wr_data == 16'hAAAA) kick_t = wcnt + 3;
            m_unl = (wr_data == 16'h5555);
          end
          2'd1: if (m_unl) begin m_psc_sh = wr_data[2:0]; m_pb = 1; psc_t = wcnt + 3; end
          2'd2: if (m_unl) begin m_rld_sh = wr_data[11:0]; m_rb = 1; rld_t = wcnt + 3; end
          default: ;
        endcase
      end
    end
  end

  // watchdog-side model
  always @(posedge wdg_clk) begin
    wcnt++;
    if (!rst_n) begin
      m_en = 0; m_bark = 0; m_psc = 0; m_rld = 'hFFF; m_cnt = 'hFFF; m_pre = 0;
    end else begin
      bit run, step, tick, bark;
      int lim;
      run  = m_en || hw_start;
      step = run && !(dbg_hold && dbg_halt);
      lim  = 4 << ((m_psc > 6) ? 6 : m_psc);
      tick = 0;
      if (!run) m_pre = 0;
      else if (step) begin
        if (m_pre >= lim - 1) begin tick = 1; m_pre = 0; end
        else m_pre++;
      end
      bark = tick && (m_cnt == 0);
      if (wcnt == kick_t || bark) m_cnt = m_rld;
      else if (tick) m_cnt = m_cnt - 1;
      m_bark = bark;
      if (wcnt == psc_t) begin m_psc = m_psc_sh; pb_t = bcnt + 2; end
      if (wcnt == rld_t) begin m_rld = m_rld_sh; rb_t = bcnt + 2; end
      if (wcnt == run_t) m_en = 1;
    end
  end

  // compare on every clock
  always @(negedge wdg_clk) begin
    vectors++;
    if (wdg_rst_o !== (rst_n ? m_bark : 1'b0)) begin
      miscompares++;
      $display("FAIL %s wdg_rst_o got %b expected %b at %0t", cur_req, wdg_rst_o, m_bark, $time);
    end
  end

  always @(negedge clk) begin
    logic [15:0] exp;
    case (rd_addr)
      2'd1:    exp = 16'(m_psc_sh);
      2'd2:    exp = 16'(m_rld_sh);
      2'd3:    exp = {14'd0, m_rb, m_pb};
      default: exp = '0;
    endcase
    vectors++;
    if (rd_data !== exp) begin
      miscompares++;
      $display("FAIL %s rd_data[addr %0d] got %h expected %h at %0t", cur_req, rd_addr, rd_data, exp, $time);
    end
  end

  initial forever begin
    @(posedge clk); #1 rd_addr = rd_addr + 2'd1;
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_w(input int n);
    repeat (n) @(negedge wdg_clk);
  endtask

  task automatic wait_idle();
    while (m_pb || m_rb) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic set_reg(input logic [1:0] a, input logic [15:0] d);
    wr(2'd0, 16'h5555);
    wr(a, d);
    wait_idle();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog expired during %s", cur_req);
    finish_run();
  end

  initial begin
    #101 rst_n = 1'b1;
    cur_req = "R10"; repeat (20) @(negedge clk);
    cur_req = "R4";  wr(2'd2, 16'h0100); wr(2'd1, 16'h0003); repeat (60) @(negedge clk);
    cur_req = "R6";  set_reg(2'd2, 16'h000F); set_reg(2'd1, 16'h0001);
    cur_req = "R4";  wr(2'd0, 16'h1234); wr(2'd2, 16'h0003); wr(2'd1, 16'h0005); repeat (40) @(negedge clk);
    cur_req = "R1";  wait_w(40); wr(2'd0, 16'hCCCC);
    cur_req = "R2";  wait_w(400);
    cur_req = "R3";
    for (int i = 0; i < 20; i++) begin wr(2'd0, 16'hAAAA); wait_w(50); end
    cur_req = "R9";  wr(2'd0, 16'h0000); wr(2'd0, 16'hDEAD); wr(2'd0, 16'h5555); wr(2'd0, 16'h0001); wait_w(300);
    cur_req = "R8";
    @(negedge wdg_clk); dbg_hold = 1'b1; dbg_halt = 1'b1; wait_w(300);
    @(negedge wdg_clk); dbg_halt = 1'b0; wait_w(200);
    @(negedge wdg_clk); dbg_hold = 1'b0; dbg_halt = 1'b1; wait_w(200);
    @(negedge wdg_clk); dbg_halt = 1'b0;
    cur_req = "R5";
    set_reg(2'd2, 16'h0000);
    set_reg(2'd1, 16'h0007); wait_w(600);
    set_reg(2'd1, 16'h0006); wait_w(600);
    set_reg(2'd1, 16'h0002); wait_w(100);
    set_reg(2'd1, 16'h0000); wait_w(40);
    cur_req = "R11";
    set_reg(2'd2, 16'h0005); wr(2'd0, 16'hAAAA); wait_w(30); wr(2'd0, 16'hAAAA); wait_w(100);
    cur_req = "R7";
    @(negedge clk); rst_n = 1'b0; hw_start = 1'b1;
    repeat (20) @(negedge clk); #1 rst_n = 1'b1;
    wait_w(20);
    set_reg(2'd2, 16'h0002); wr(2'd0, 16'hAAAA); wait_w(200);
    finish_run();
  end
endmodule